// File: doc/BRIEF.md
# Linked-Packet Chain Walker

This block follows a chain of packets kept in main memory and pushes the payload of each packet, word by word, into a peripheral stream such as a graphics command queue. Every packet opens with one 32-bit header word. Its upper eight bits give the number of payload words. Its lower 24 bits give the byte address of the following header. The payload words sit directly after the header. The walker reads them through a single-outstanding word-read port and offers them on a valid/ready stream.

A pulse on `start` with a base address begins a walk. The walker stops in three cases: the next pointer is the end-of-chain sentinel 0xFFFFFF, a header points to itself, or two headers point to each other. Long chains are split into bursts. Once the count of header and payload words read exceeds a fixed budget, the walker saves its position in `cur_base`, stays idle for a set number of cycles, and then carries on from that position. A one-cycle `done` pulse marks the end of each walk. Register decode, interrupt generation and memory arbitration belong to the surrounding channel logic.

Top module: `chain_walker`

## Requirements
- R1: A header at masked address H is read first. Bits 31:24 give the payload count N and bits 23:0 give the next pointer. The N words at H+4, H+8, … H+4N (each masked) then go out in address order. While `mem_req` is high and `mem_rvalid` is low, `mem_addr` holds steady.
- R2: When the next pointer is 0xFFFFFF, `cur_base` becomes 0xFFFFFF. `waiting` then stays high for exactly END_CYC cycles, and `done` follows.
- R3: Every address driven on `mem_addr` is ANDed with (2^AW − 1). Address bits at or above AW never appear, and payload addresses wrap inside the RAM.
- R4: Before each header fetch, the walker compares its running total of header-plus-payload words against BUDGET. If the total is greater, it loads the pending header address into `cur_base` and raises `waiting` for exactly PAUSE_CYC cycles. During that time it issues no memory request and offers no stream word. It then clears the total and resumes from `cur_base`.
- R5: A header whose next pointer equals its own masked address ends the walk after its payload, with no delay and with `cur_base` unchanged.
- R6: If the header at the next pointer has a next pointer (bits 23:0) equal to the current header address, the walk ends after the current payload, with no delay.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. No word is dropped or repeated.
- R8: A start with base 0xFFFFFF finishes at once with `done`, issues no memory request, and sets `cur_base` to 0xFFFFFF.
- R9: `done` lasts one cycle, after which `busy` is low. A `start` pulse while `busy` is high is ignored.
- R10: After reset, `busy`, `waiting`, `done`, `mem_req` and `out_valid` are low and `cur_base` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at `start_base` |
| start_base | input | 24 | First header byte address |
| busy | output | 1 | Walk in progress |
| waiting | output | 1 | Pause or end-of-chain delay running |
| done | output | 1 | One-cycle walk-finished pulse |
| cur_base | output | 24 | Saved resume / final base address |
| mem_req | output | 1 | Word read request, held until `mem_rvalid` |
| mem_addr | output | 24 | Masked byte address of the read |
| mem_rvalid | input | 1 | Read data returned (one-cycle pulse) |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Peripheral accepts the word |

## Verification
The bench runs a set of chains that each separate one behaviour from the others:
- A plain three-packet chain that includes an empty packet. It shows that header parsing and payload order are correct.
- The same chain with random back-pressure and random memory latency. It shows that stalls neither drop nor repeat words.
- A chain whose payload runs off the top of the RAM, started from a base with high address bits set. It shows the masking and the wrap.
- A five-packet chain that crosses the budget. It is told apart by its one pause of PAUSE_CYC cycles, followed by an end delay of END_CYC cycles.
- A self-loop and a two-node loop. Each must end without delay after exactly one payload.
- A sentinel start, which must end without any reads.
- A second `start` pulse during a walk, which must leave the stream unchanged.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int PTR_W = 24;
  localparam int WORD_W = 32;
  localparam logic [PTR_W-1:0] CHAIN_END = 24'hFF_FFFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_HDR,
    S_DATA,
    S_SEND,
    S_LINK,
    S_PEEK,
    S_WAIT
  } cw_state_t;
endpackage

// File: rtl/cw_timer.sv
module cw_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/cw_tally.sv
module cw_tally #(
  parameter int TW     = 18,
  parameter int LEN_W  = 8,
  parameter int BUDGET = 65535
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add,
  input  logic [LEN_W-1:0] amount,
  output logic             over
);
  logic [TW-1:0] tot_q, tot_d;
  logic          tot_en;

  always_comb begin
    tot_en = clear || add;
    tot_d  = clear ? '0 : tot_q + TW'(amount) + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tot_q <= '0;
    else if (tot_en) tot_q <= tot_d;
  end

  assign over = (tot_q > TW'(BUDGET));
endmodule

// File: rtl/cw_outreg.sv
module cw_outreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic vld_q, vld_d;
  logic [DW-1:0] dat_q;

  always_comb begin
    vld_d = vld_q;
    if (load)                vld_d = 1'b1;
    else if (vld_q && out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) dat_q <= load_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import cw_pkg::*;
#(
  parameter int AW        = 12,
  parameter int LEN_W     = 8,
  parameter int BUDGET    = 65535,
  parameter int PAUSE_CYC = 16000,
  parameter int END_CYC   = 19000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] start_base,
  output logic        busy,
  output logic        waiting,
  output logic        done,
  output logic [23:0] cur_base,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready
);
  localparam logic [PTR_W-1:0] MASK = PTR_W'((64'd1 << AW) - 64'd1);
  localparam int DMAX = (PAUSE_CYC > END_CYC) ? PAUSE_CYC : END_CYC;
  localparam int CW   = $clog2(DMAX + 1);
  localparam int TW   = $clog2(BUDGET + (2 ** LEN_W) + 2) + 1;

  cw_state_t         st_q, st_d;
  logic [PTR_W-1:0]  walk_q, walk_d;
  logic [PTR_W-1:0]  hdr_q, hdr_d;
  logic [PTR_W-1:0]  nxt_q, nxt_d;
  logic [PTR_W-1:0]  wad_q, wad_d;
  logic [PTR_W-1:0]  base_q, base_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              fresh_q, fresh_d;
  logic              fin_q, fin_d;
  logic              done_q, done_d;

  logic              tm_load, tm_last;
  logic [CW-1:0]     tm_val;
  logic              tl_clear, tl_add, tl_over;
  logic              ob_load, ob_valid;
  logic [LEN_W-1:0]  hdr_len;
  logic [PTR_W-1:0]  hdr_next;

  assign hdr_len  = mem_rdata[WORD_W-1 -: LEN_W];
  assign hdr_next = mem_rdata[PTR_W-1:0];

  cw_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .last(tm_last)
  );

  cw_tally #(.TW(TW), .LEN_W(LEN_W), .BUDGET(BUDGET)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(tl_clear), .add(tl_add),
    .amount(hdr_len), .over(tl_over)
  );

  cw_outreg #(.DW(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(ob_load), .load_data(mem_rdata),
    .out_ready(out_ready), .out_valid(ob_valid), .out_data(out_data)
  );

  always_comb begin
    st_d     = st_q;
    walk_d   = walk_q;
    hdr_d    = hdr_q;
    nxt_d    = nxt_q;
    wad_d    = wad_q;
    base_d   = base_q;
    left_d   = left_q;
    fresh_d  = fresh_q;
    fin_d    = fin_q;
    done_d   = 1'b0;
    tm_load  = 1'b0;
    tm_val   = CW'(PAUSE_CYC);
    tl_clear = 1'b0;
    tl_add   = 1'b0;
    ob_load  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          walk_d   = start_base;
          base_d   = start_base;
          fresh_d  = 1'b1;
          tl_clear = 1'b1;
          st_d     = S_CHECK;
        end
      end
      S_CHECK: begin
        fresh_d = 1'b0;
        if (walk_q == CHAIN_END) begin
          if (fresh_q) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            base_d  = walk_q;
            fin_d   = 1'b1;
            tm_load = 1'b1;
            tm_val  = CW'(END_CYC);
            st_d    = S_WAIT;
          end
        end else if (tl_over) begin
          base_d  = walk_q;
          fin_d   = 1'b0;
          tm_load = 1'b1;
          tm_val  = CW'(PAUSE_CYC);
          st_d    = S_WAIT;
        end else begin
          hdr_d = walk_q & MASK;
          st_d  = S_HDR;
        end
      end
      S_HDR: begin
        if (mem_rvalid) begin
          left_d = hdr_len;
          nxt_d  = hdr_next;
          wad_d  = (hdr_q + PTR_W'(4)) & MASK;
          tl_add = 1'b1;
          st_d   = (hdr_len == '0) ? S_LINK : S_DATA;
        end
      end
      S_DATA: begin
        if (mem_rvalid) begin
          ob_load = 1'b1;
          st_d    = S_SEND;
        end
      end
      S_SEND: begin
        if (out_ready) begin
          wad_d  = (wad_q + PTR_W'(4)) & MASK;
          left_d = left_q - 1'b1;
          st_d   = (left_q == LEN_W'(1)) ? S_LINK : S_DATA;
        end
      end
      S_LINK: begin
        if (nxt_q == hdr_q) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (nxt_q == CHAIN_END) begin
          walk_d = nxt_q;
          st_d   = S_CHECK;
        end else begin
          st_d = S_PEEK;
        end
      end
      S_PEEK: begin
        if (mem_rvalid) begin
          if (hdr_next == hdr_q) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            walk_d = nxt_q;
            st_d   = S_CHECK;
          end
        end
      end
      S_WAIT: begin
        if (tm_last) begin
          if (fin_q) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            tl_clear = 1'b1;
            st_d     = S_CHECK;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      walk_q  <= '0;
      hdr_q   <= '0;
      nxt_q   <= '0;
      wad_q   <= '0;
      base_q  <= '0;
      left_q  <= '0;
      fresh_q <= 1'b0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      walk_q  <= walk_d;
      hdr_q   <= hdr_d;
      nxt_q   <= nxt_d;
      wad_q   <= wad_d;
      base_q  <= base_d;
      left_q  <= left_d;
      fresh_q <= fresh_d;
      fin_q   <= fin_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = '0;
    unique case (st_q)
      S_HDR:  begin mem_req = 1'b1; mem_addr = hdr_q; end
      S_DATA: begin mem_req = 1'b1; mem_addr = wad_q; end
      S_PEEK: begin mem_req = 1'b1; mem_addr = nxt_q & MASK; end
      default: ;
    endcase
  end

  assign busy      = (st_q != S_IDLE);
  assign waiting   = (st_q == S_WAIT);
  assign done      = done_q;
  assign cur_base  = base_q;
  assign out_valid = ob_valid;
endmodule

// File: rtl/cw_check.sv
module cw_check #(
  parameter int AW = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        waiting,
  input logic        done,
  input logic        mem_req,
  input logic [23:0] mem_addr,
  input logic        mem_rvalid,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_ready
);
  localparam logic [23:0] MASK = 24'((64'd1 << AW) - 64'd1);

  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R3
  addr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & ~MASK) == 24'd0));

  // R4
  quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !mem_req && !out_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind chain_walker cw_check #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .waiting(waiting), .done(done),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
);

// File: tb/chain_walker_test.sv
module chain_walker_test;
  localparam int AW = 10;
  localparam int BUDGET = 20;
  localparam int PAUSE_CYC = 7;
  localparam int END_CYC = 5;
  localparam int WORDS = 256;
  localparam logic [23:0] MASK = 24'h0003FF;
  localparam logic [23:0] SENT = 24'hFFFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] start_base = '0;
  logic busy, waiting, done, mem_req, out_valid;
  logic [23:0] cur_base, mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] out_data;
  logic out_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit bp = 0;
  bit slow = 0;
  logic [31:0] mem [WORDS];
  logic [31:0] exp_q [$];
  int wait_q [$];
  logic [23:0] exp_base;
  int wcnt = 0;
  int req_cnt = 0;
  bit prev_stall = 0;
  logic [31:0] prev_data = '0;

  always #5 clk = ~clk;

  chain_walker #(.AW(AW), .LEN_W(8), .BUDGET(BUDGET), .PAUSE_CYC(PAUSE_CYC),
                 .END_CYC(END_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .busy(busy), .waiting(waiting), .done(done), .cur_base(cur_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder
  always @(posedge clk) begin
    if (mem_req && !mem_rvalid && (!slow || $urandom_range(0, 2) == 0)) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[(mem_addr >> 2) % WORDS];
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  // peripheral ready
  always @(posedge clk) begin
    #2;
    out_ready = bp ? ($urandom_range(0, 1) == 1) : 1'b1;
  end

  // per-clock comparison against the reference stream
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (mem_req) begin
        req_cnt++;
        // R3
        chk((mem_addr & ~MASK) == 0, "R3", "address above RAM", {8'h0, mem_addr}, 0);
      end
      if (prev_stall) begin
        // R7
        chk(out_valid && out_data == prev_data, "R7", "stalled word changed",
            out_data, prev_data);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(0, "R1", "unexpected stream word", out_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R1", "payload word", out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (waiting) begin
        wcnt++;
        // R4
        chk(!mem_req && !out_valid, "R4", "activity while waiting",
            {mem_req, out_valid}, 0);
      end else if (wcnt > 0) begin
        if (wait_q.size() == 0)
          chk(0, "R4", "unexpected delay", wcnt, 0);
        else begin
          int w;
          w = wait_q.pop_front();
          chk(wcnt == w, (w == END_CYC) ? "R2" : "R4", "delay length", wcnt, w);
        end
        wcnt = 0;
      end
    end
  end

  function automatic void hdr(input logic [23:0] a, input int n, input logic [23:0] nx);
    mem[(a >> 2) % WORDS] = {8'(n), nx};
  endfunction

  function automatic void model(input logic [23:0] base);
    logic [23:0] a, h, nx;
    logic [31:0] w;
    int total, n;
    bit fresh;
    exp_q.delete();
    wait_q.delete();
    exp_base = base;
    a = base;
    total = 0;
    fresh = 1;
    for (int it = 0; it < 1000; it++) begin
      if (a == SENT) begin
        if (!fresh) begin
          exp_base = SENT;
          wait_q.push_back(END_CYC);
        end
        return;
      end
      fresh = 0;
      if (total > BUDGET) begin
        exp_base = a;
        wait_q.push_back(PAUSE_CYC);
        total = 0;
        continue;
      end
      h = a & MASK;
      w = mem[h >> 2];
      n = int'(w[31:24]);
      nx = w[23:0];
      for (int k = 1; k <= n; k++)
        exp_q.push_back(mem[((h + 24'(4 * k)) & MASK) >> 2]);
      total += n + 1;
      if (nx == h) return;
      if (nx != SENT && mem[(nx & MASK) >> 2][23:0] == h) return;
      a = nx;
    end
  endfunction

  task automatic run(input logic [23:0] base, input bit extra_start, input string req);
    int t;
    model(base);
    req_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    start_base = base;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      start_base = 24'h000300;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done, req, "done seen", done, 1);
    @(negedge clk);
    // R9
    chk(!done && !busy, "R9", "done one cycle then idle", {done, busy}, 0);
    @(negedge clk);
    chk(exp_q.size() == 0, req, "words left unsent", exp_q.size(), 0);
    chk(wait_q.size() == 0, req, "delays missing", wait_q.size(), 0);
    chk(cur_base == exp_base, req, "saved base", cur_base, exp_base);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_9E37);
    hdr(24'h040, 2, 24'h080);
    hdr(24'h080, 0, 24'h100);
    hdr(24'h100, 3, SENT);
    hdr(24'h3F8, 3, 24'h200);
    hdr(24'h200, 1, SENT);
    hdr(24'h010, 6, 24'h050);
    hdr(24'h050, 6, 24'h090);
    hdr(24'h090, 6, 24'h0D0);
    hdr(24'h0D0, 6, 24'h110);
    hdr(24'h110, 6, SENT);
    hdr(24'h300, 2, 24'h300);
    hdr(24'h180, 1, 24'h1C0);
    hdr(24'h1C0, 1, 24'h180);

    repeat (3) @(negedge clk);
    // R10
    chk(!busy && !waiting && !done && !mem_req && !out_valid && cur_base == 0,
        "R10", "reset state", {busy, waiting, done, mem_req, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R10", "idle after reset release", {busy, mem_req}, 0);

    run(24'h000040, 0, "R1");          // R1 plain chain, R2 end delay
    bp = 1; slow = 1;
    run(24'h000040, 0, "R7");          // R7 back-pressure and latency
    bp = 0; slow = 0;
    run(24'h0013F8, 0, "R3");          // R3 high bits and payload wrap
    bp = 1;
    run(24'h000010, 0, "R4");          // R4 budget pause then resume
    bp = 0;
    run(24'h000300, 0, "R5");          // R5 self-loop
    run(24'h000180, 0, "R6");          // R6 two-node loop
    run(SENT, 0, "R8");                // R8 sentinel start
    chk(req_cnt == 0, "R8", "no read on sentinel start", req_cnt, 0);
    slow = 1;
    run(24'h000040, 1, "R9");          // R9 start ignored while busy
    slow = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule